// File: doc/BRIEF.md
# Predicate-Compacting Wavefront Issue Scheduler

This block schedules the threads of a wide wavefront onto a narrower SIMD array. A wavefront of 256 threads is spread over 16 ALU lanes, and each lane owns a fixed group of 16 threads. A start pulse delivers a 256-bit active-predicate mask. From then on, each lane works through only its own active threads, one per cycle, lowest index first. It skips threads whose predicate is clear. A divergent wavefront therefore finishes in as many cycles as its busiest lane has active threads, rather than always taking 16.

Operand read takes a fixed 4 cycles, so a wavefront is never allowed to finish sooner than that. A done pulse marks the last issue cycle, which is the later of the slowest lane draining and the 4-cycle floor. The block produces only the per-lane issue sequence and its timing. The operand path, the ALUs and writeback are the job of the surrounding logic.

Top module: `wave_compact_issue`

## Requirements
- R1: After reset, busy, done and every lane_valid bit are low.
- R2: A start pulse sampled while busy is low loads pred_mask, and busy is high from the next cycle on. The first issue cycle is the first cycle in which busy is high.
- R3: Lane L reports on lane_idx bits [4L+3:4L] a local index j, which names thread L*16+j and mask bit L*16+j. On each issue cycle the lane reports the lowest-indexed active thread it has not yet issued, so the indices of a lane rise strictly within a wavefront. lane_idx of a lane is 0 whenever its lane_valid bit is low.
- R4: Each lane issues at most one thread per cycle, and every thread whose mask bit is 1 is issued exactly once.
- R5: A lane with no active threads in the mask keeps lane_valid low for the whole wavefront. A lane that has drained stays invalid for the rest of the wavefront.
- R6: A wavefront takes max(4, N) issue cycles, where N is the largest per-lane count of set mask bits. done is high during the last of these cycles only.
- R7: An all-zero mask still takes 4 issue cycles, raises no lane_valid, and raises done in the 4th cycle.
- R8: A start pulse that arrives while busy is high is ignored and does not change the issue sequence.
- R9: busy goes low in the cycle after done. While busy is low, done and all lane_valid bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a wavefront when the block is idle |
| pred_mask | input | 256 | Active-predicate mask, bit L*16+j for thread j of lane L |
| busy | output | 1 | High on every issue cycle of a wavefront |
| done | output | 1 | High on the final issue cycle |
| lane_valid | output | 16 | Per-lane issue valid |
| lane_idx | output | 64 | Per-lane 4-bit local thread index, lane L at [4L+3:4L] |

## Verification
The assertions assume that start and pred_mask are sampled only on clock edges. They place no limit on when start may rise, so a start during a busy wavefront has to be rejected by the design itself. The floor check relies on a busy-cycle counter kept in the checker. The stimulus drives inputs only at falling edges and holds start for one cycle. It deliberately raises a second start with the inverted mask partway through a wavefront. It mixes full, empty, single-thread, single-lane and pseudo-random sparse and dense masks, so the expected cycle count falls both below and above the floor.

// File: rtl/wave_compact_issue.sv
module wave_compact_issue #(
  parameter int LANES   = 16,
  parameter int TPL     = 16,
  parameter int MIN_CYC = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [LANES*TPL-1:0]            pred_mask,
  output logic                            busy,
  output logic                            done,
  output logic [LANES-1:0]                lane_valid,
  output logic [LANES*$clog2(TPL)-1:0]    lane_idx
);
  localparam int IW = $clog2(TPL);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [TPL-1:0] ONE = TPL'(1);

  logic [LANES*TPL-1:0] pend, pend_nxt;
  logic [LANES-1:0]     last;
  logic [CW-1:0]        cyc;
  logic                 floor_met;

  assign floor_met = (cyc == CW'(MIN_CYC - 1));
  assign done      = busy & floor_met & (&last);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TPL-1:0] p;
    logic [IW-1:0]  sel;
    assign p = pend[l*TPL +: TPL];
    always_comb begin
      sel = '0;
      for (int j = TPL - 1; j >= 0; j--)
        if (p[j]) sel = IW'(j);
    end
    assign lane_valid[l]           = busy & (|p);
    assign lane_idx[l*IW +: IW]    = lane_valid[l] ? sel : '0;
    assign last[l]                 = ((p & (p - ONE)) == '0);
    assign pend_nxt[l*TPL +: TPL]  = p & (p - ONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= '0;
      cyc  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        pend <= pred_mask;
        cyc  <= '0;
      end
    end else begin
      pend <= pend_nxt;
      if (!floor_met) cyc <= cyc + CW'(1);
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/wave_compact_issue_chk.sv
module wave_compact_issue_chk #(
  parameter int LANES   = 16,
  parameter int TPL     = 16,
  parameter int MIN_CYC = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic [LANES*TPL-1:0]         pred_mask,
  input logic                         busy,
  input logic                         done,
  input logic [LANES-1:0]             lane_valid,
  input logic [LANES*$clog2(TPL)-1:0] lane_idx
);
  localparam int IW = $clog2(TPL);
  logic [7:0] bc;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) bc <= '0;
    else if (bc != 8'hFF) bc <= bc + 8'd1;
  end

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_valid == '0 && !done));
  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bc >= 8'(MIN_CYC - 1)));
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && lane_valid[l]) |=>
        (!lane_valid[l] || lane_idx[l*IW +: IW] > $past(lane_idx[l*IW +: IW])));
    p_stay_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !lane_valid[l]) |=> !lane_valid[l]);
  end
endmodule

bind wave_compact_issue wave_compact_issue_chk #(.LANES(LANES), .TPL(TPL), .MIN_CYC(MIN_CYC)) u_chk (.*);

// File: tb/sim_wave_compact_issue.sv
module sim_wave_compact_issue;
  localparam int LANES = 16, TPL = 16, MIN_CYC = 4, IW = 4;

  typedef struct packed {
    logic [LANES-1:0]    v;
    logic [LANES*IW-1:0] ix;
    logic                dn;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LANES*TPL-1:0] pred_mask = '0;
  logic busy, done;
  logic [LANES-1:0] lane_valid;
  logic [LANES*IW-1:0] lane_idx;

  item_t q[$];
  int checks = 0, fails = 0;
  string cur_tag = "";

  always #5 clk = ~clk;

  wave_compact_issue u0 (.clk(clk), .rst_n(rst_n), .start(start), .pred_mask(pred_mask),
    .busy(busy), .done(done), .lane_valid(lane_valid), .lane_idx(lane_idx));

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", what, cur_tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per issue cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (busy) begin
          if (q.size() == 0) chk(1'b0, "R6 extra issue cycle", 128'(busy), 128'(0));
          else begin
            item_t e;
            e = q.pop_front();
            chk(lane_valid == e.v, "R4/R5 lane_valid", 128'(lane_valid), 128'(e.v));
            chk(lane_idx == e.ix, "R3 lane_idx", 128'(lane_idx), 128'(e.ix));
            chk(done == e.dn, "R6 done", 128'(done), 128'(e.dn));
          end
        end else begin
          chk(lane_valid == '0 && !done, "R9 idle outputs", 128'({lane_valid, done}), 128'(0));
        end
      end
    end
  end

  // driver: computes the expected issue sequence, then starts the wavefront
  task automatic run_wave(input logic [LANES*TPL-1:0] m, input bit poke, input string tag);
    int cnt [LANES];
    int n = MIN_CYC;
    cur_tag = tag;
    for (int l = 0; l < LANES; l++) begin
      cnt[l] = 0;
      for (int j = 0; j < TPL; j++) if (m[l*TPL+j]) cnt[l]++;
      if (cnt[l] > n) n = cnt[l];
    end
    for (int c = 0; c < n; c++) begin
      item_t e;
      e = '0;
      for (int l = 0; l < LANES; l++) begin
        int k = 0;
        for (int j = 0; j < TPL; j++) begin
          if (m[l*TPL+j]) begin
            if (k == c) begin
              e.v[l] = 1'b1;
              e.ix[l*IW +: IW] = IW'(j);
            end
            k++;
          end
        end
      end
      e.dn = (c == n - 1);
      q.push_back(e);
    end
    @(negedge clk); start = 1'b1; pred_mask = m;
    @(negedge clk); start = 1'b0; pred_mask = '0;
    chk(busy == 1'b1, "R2 busy after start", 128'(busy), 128'(1));
    if (poke) begin  // R8: second start while busy
      @(negedge clk); start = 1'b1; pred_mask = ~m;
      @(negedge clk); start = 1'b0; pred_mask = '0;
    end
    while (busy) @(negedge clk);
    chk(q.size() == 0, "R6 issue cycle count", 128'(q.size()), 128'(0));
    q.delete();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lf = 32'hACE1_1234;
    logic [LANES*TPL-1:0] a, b;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && lane_valid == '0, "R1 reset state",
        128'({busy, done, lane_valid}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && lane_valid == '0, "R1 after reset release", 128'({busy, lane_valid}), 128'(0));

    run_wave('1, 1'b0, "R4 all active");
    run_wave('0, 1'b0, "R7 all zero");
    run_wave(256'(1) << 37, 1'b0, "R6 single thread");
    run_wave(256'(16'hFFFF), 1'b0, "R5 lane0 full only");
    run_wave({64{4'b1000}}, 1'b0, "R6 every fourth");
    run_wave({{15{16'h0000}}, 16'h007F} | (256'(16'h8001) << 128), 1'b0, "R3 seven deep");
    run_wave('1, 1'b1, "R8 start while busy full");
    run_wave({64{4'b0010}}, 1'b1, "R8 start while busy sparse");
    for (int r = 0; r < 10; r++) begin
      for (int w = 0; w < 8; w++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} ^ 32'(r * 7919 + w);
        a[w*32 +: 32] = lf;
        lf = lf * 32'd1103515245 + 32'd12345;
        b[w*32 +: 32] = lf;
      end
      run_wave((r % 2 == 0) ? (a & b) : (a | b), r == 3, "R4 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule